// File: doc/BRIEF.md
# Configuration Access Translator

This block sits between the configuration-request side of a root port and its register and memory fabric. It takes one request at a time, naming a bus, a device, a function and a byte offset, with a read or write direction, byte enables and write data. It turns that request into a single word-aligned access, either on the root port's own register space or through an outbound window into the downstream hierarchy. For window accesses it produces the routing word and the configuration request type that the outbound translation stage needs.

Device numbers that cannot exist behind the root port are filtered out before any access is issued. A filtered read answers with all ones, and a filtered write answers with an error. A write that covers only part of a word is done as a read of the full word, a merge of the enabled bytes, then a full-word write. An access that aborts because nobody answered yields all ones, never stale data.

Top module: `cfg_access_xlate`

## Requirements
- R1: `reqReady` is high only while the block is idle, and a request is taken on a clock edge where both `reqValid` and `reqReady` are high. Exactly one single-cycle `rspValid` pulse follows each accepted request, and no further request is taken before that pulse.
- R2: A request is invalid when its bus is 0 and its device is above 1, or when its bus is 1 and its device is above 0. Every other combination is valid.
- R3: An invalid read makes no access (`memValid` stays low) and responds with `rspRdata` = 0xFFFFFFFF and `rspError` = 0.
- R4: An invalid write makes no access and responds with `rspError` = 1.
- R5: Every access has `memLocal` = 1 when the bus is 0 and `memLocal` = 0 for any other bus.
- R6: `memType` is 4'h4 (type-0 configuration) for buses 0 and 1, and 4'h5 (type-1) for every higher bus.
- R7: For window accesses, `memTarget` carries the bus in bits 31:24, the device in bits 23:19, the function in bits 18:16, and zeros in bits 15:0.
- R8: `memAddr` equals the request offset with bits 1:0 cleared.
- R9: A valid read responds with `memRdata` taken at the `memAck` cycle. If `memAbort` is high at that cycle, the response is 0xFFFFFFFF instead.
- R10: A valid write with `reqByteEn` = 4'hF makes exactly one access, a write carrying `reqWdata`, with no read, and responds with `rspError` = 0.
- R11: A valid write with any other `reqByteEn` first reads the word, then writes it back. In that write, byte lane i (bits 8i+7:8i) comes from `reqWdata` when `reqByteEn[i]` is set and from the read word otherwise. A read that aborted contributes all ones.
- R12: Once `memValid` rises it stays high, with direction, address, target and type held stable, until the cycle in which `memAck` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqBus | input | 8 | Bus number |
| reqDev | input | 5 | Device number |
| reqFunc | input | 3 | Function number |
| reqOffset | input | OFS_W | Byte offset into configuration space |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqByteEn | input | 4 | Byte enables for a write |
| reqWdata | input | 32 | Write data |
| memValid | output | 1 | Access request to the fabric |
| memAck | input | 1 | Access completed this cycle |
| memLocal | output | 1 | 1 selects local root-port registers, 0 selects the outbound window |
| memWrite | output | 1 | Access direction |
| memType | output | 4 | Configuration request type code |
| memTarget | output | 32 | Routing word for the outbound window |
| memAddr | output | OFS_W | Word-aligned offset |
| memWdata | output | 32 | Write data of the access |
| memRdata | input | 32 | Read data returned with memAck |
| memAbort | input | 1 | Access aborted, returned with memAck |
| rspValid | output | 1 | Response pulse |
| rspRdata | output | 32 | Read result |
| rspError | output | 1 | Request rejected |

## Verification
The bench aims at the bus/device boundary cells: bus 0 with devices 1 and 2, bus 1 with devices 0 and 1, and bus 2 upward. A design that gets these wrong either issues an access to a device that cannot exist or refuses a legal one. It also targets the switch between type codes at bus 2 and the field packing of the routing word, where an off-by-one shift corrupts the device or function seen downstream. Sub-word writes come with mixed and empty byte enables, and with an aborting target. A merge that skipped the read, took lanes the wrong way round, or kept stale data after an abort would leave the wrong word in the fabric model. Unaligned offsets at the end of the range catch an address that is not cleared to the word boundary.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FUNC_W = 3;
  localparam int TGT_W  = 32;
  localparam int TYPE_W = 4;

  localparam logic [TYPE_W-1:0] CFG_TYPE_LOCALSEG = 4'h4;
  localparam logic [TYPE_W-1:0] CFG_TYPE_FORWARD  = 4'h5;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic capRd;
    logic markInvalid;
  } cfgx_strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic invalid;
    logic isWrite;
    logic fullWord;
  } cfgx_status_t;

endpackage

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  input  logic         memAck,
  output logic         memValid,
  output logic         memWrite,
  output logic         rspValid,
  input  cfgx_status_t sts,
  output cfgx_strobe_t stb
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DISPATCH,
    ST_READ,
    ST_WRITE,
    ST_RESPOND
  } ctrlState_t;

  ctrlState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          stb.load = 1'b1;
          stateD   = ST_DISPATCH;
        end
      end
      ST_DISPATCH: begin
        if (sts.invalid) begin
          stb.markInvalid = 1'b1;
          stateD          = ST_RESPOND;
        end else if (sts.isWrite && sts.fullWord) begin
          stateD = ST_WRITE;
        end else begin
          stateD = ST_READ;
        end
      end
      ST_READ: begin
        if (memAck) begin
          stb.capRd = 1'b1;
          stateD    = sts.isWrite ? ST_WRITE : ST_RESPOND;
        end
      end
      ST_WRITE: begin
        if (memAck) stateD = ST_RESPOND;
      end
      ST_RESPOND: stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign memValid = (stateQ == ST_READ) || (stateQ == ST_WRITE);
  assign memWrite = (stateQ == ST_WRITE);
  assign rspValid = (stateQ == ST_RESPOND);

  AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memValid && !rspValid)); // R1

  AST_NO_ACCESS_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !sts.invalid); // R3

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memAck) |=> (memValid && $stable(memWrite))); // R12

endmodule

// File: rtl/cfgx_datapath.sv
module cfgx_datapath
  import cfgx_pkg::*;
#(
  parameter int OFS_W        = 12,
  parameter int DATA_W       = 32,
  parameter int ROOT_DEV_MAX = 1,
  parameter int LINK_DEV_MAX = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgx_strobe_t         stb,
  output cfgx_status_t         sts,
  input  logic [BUS_W-1:0]     reqBus,
  input  logic [DEV_W-1:0]     reqDev,
  input  logic [FUNC_W-1:0]    reqFunc,
  input  logic [OFS_W-1:0]     reqOffset,
  input  logic                 reqWrite,
  input  logic [DATA_W/8-1:0]  reqByteEn,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 memLocal,
  output logic [TYPE_W-1:0]    memType,
  output logic [TGT_W-1:0]     memTarget,
  output logic [OFS_W-1:0]     memAddr,
  output logic [DATA_W-1:0]    memWdata,
  input  logic [DATA_W-1:0]    memRdata,
  input  logic                 memAbort,
  output logic [DATA_W-1:0]    rspRdata,
  output logic                 rspError
);

  localparam int LANES   = DATA_W / 8;
  localparam int ALIGN_W = $clog2(LANES);
  localparam logic [DEV_W-1:0] ROOT_LIM = DEV_W'(ROOT_DEV_MAX);
  localparam logic [DEV_W-1:0] LINK_LIM = DEV_W'(LINK_DEV_MAX);

  logic [BUS_W-1:0]  busQ;
  logic [DEV_W-1:0]  devQ;
  logic [FUNC_W-1:0] funcQ;
  logic [OFS_W-1:0]  offQ;
  logic              wrQ;
  logic [LANES-1:0]  beQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdQ;
  logic              errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busQ   <= '0;
      devQ   <= '0;
      funcQ  <= '0;
      offQ   <= '0;
      wrQ    <= 1'b0;
      beQ    <= '0;
      wdataQ <= '0;
      rdQ    <= '0;
      errQ   <= 1'b0;
    end else begin
      if (stb.load) begin
        busQ   <= reqBus;
        devQ   <= reqDev;
        funcQ  <= reqFunc;
        offQ   <= reqOffset;
        wrQ    <= reqWrite;
        beQ    <= reqByteEn;
        wdataQ <= reqWdata;
        errQ   <= 1'b0;
      end
      if (stb.markInvalid) begin
        rdQ  <= '1;
        errQ <= wrQ;
      end
      if (stb.capRd) rdQ <= memAbort ? '1 : memRdata;
    end
  end

  // device filter: only the root port and its single link partner exist
  logic onRoot, onLink;
  assign onRoot = (busQ == '0);
  assign onLink = (busQ == BUS_W'(1));

  assign sts.invalid  = (onRoot && (devQ > ROOT_LIM)) || (onLink && (devQ > LINK_LIM));
  assign sts.isWrite  = wrQ;
  assign sts.fullWord = &beQ;

  assign memLocal  = onRoot;
  assign memType   = (busQ < BUS_W'(2)) ? CFG_TYPE_LOCALSEG : CFG_TYPE_FORWARD;
  assign memTarget = {busQ, devQ, funcQ, {(TGT_W-BUS_W-DEV_W-FUNC_W){1'b0}}};
  assign memAddr   = {offQ[OFS_W-1:ALIGN_W], {ALIGN_W{1'b0}}};

  // byte-lane merge of new data over the word read back
  for (genvar lane = 0; lane < LANES; lane++) begin : gMerge
    assign memWdata[lane*8 +: 8] = beQ[lane] ? wdataQ[lane*8 +: 8] : rdQ[lane*8 +: 8];
  end

  assign rspRdata = rdQ;
  assign rspError = errQ;

  AST_ABORT_GIVES_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capRd && memAbort) |=> (rspRdata == '1)); // R9

  AST_INVALID_WRITE_ERRS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.markInvalid && sts.isWrite) |=> rspError); // R4

endmodule

// File: rtl/cfg_access_xlate.sv
module cfg_access_xlate
  import cfgx_pkg::*;
#(
  parameter int OFS_W        = 12,
  parameter int DATA_W       = 32,
  parameter int ROOT_DEV_MAX = 1,
  parameter int LINK_DEV_MAX = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [7:0]          reqBus,
  input  logic [4:0]          reqDev,
  input  logic [2:0]          reqFunc,
  input  logic [OFS_W-1:0]    reqOffset,
  input  logic                reqWrite,
  input  logic [DATA_W/8-1:0] reqByteEn,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                memValid,
  input  logic                memAck,
  output logic                memLocal,
  output logic                memWrite,
  output logic [3:0]          memType,
  output logic [31:0]         memTarget,
  output logic [OFS_W-1:0]    memAddr,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata,
  input  logic                memAbort,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspRdata,
  output logic                rspError
);

  cfgx_strobe_t stb;
  cfgx_status_t sts;

  cfgx_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .memAck   (memAck),
    .memValid (memValid),
    .memWrite (memWrite),
    .rspValid (rspValid),
    .sts      (sts),
    .stb      (stb)
  );

  cfgx_datapath #(
    .OFS_W        (OFS_W),
    .DATA_W       (DATA_W),
    .ROOT_DEV_MAX (ROOT_DEV_MAX),
    .LINK_DEV_MAX (LINK_DEV_MAX)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .sts       (sts),
    .reqBus    (reqBus),
    .reqDev    (reqDev),
    .reqFunc   (reqFunc),
    .reqOffset (reqOffset),
    .reqWrite  (reqWrite),
    .reqByteEn (reqByteEn),
    .reqWdata  (reqWdata),
    .memLocal  (memLocal),
    .memType   (memType),
    .memTarget (memTarget),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memRdata  (memRdata),
    .memAbort  (memAbort),
    .rspRdata  (rspRdata),
    .rspError  (rspError)
  );

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memAck) |=> ($stable(memAddr) && $stable(memTarget) && $stable(memType))); // R12

  AST_LOCAL_IS_TYPE0: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memLocal) |-> (memType == 4'h4)); // R6

endmodule

// File: tb/test_cfg_access_xlate.sv
module test_cfg_access_xlate;

  localparam int CLK_PERIOD = 10;
  localparam int OFS_W      = 12;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             reqValid = 1'b0;
  logic             reqReady;
  logic [7:0]       reqBus = '0;
  logic [4:0]       reqDev = '0;
  logic [2:0]       reqFunc = '0;
  logic [OFS_W-1:0] reqOffset = '0;
  logic             reqWrite = 1'b0;
  logic [3:0]       reqByteEn = '0;
  logic [31:0]      reqWdata = '0;
  logic             memValid;
  logic             memAck = 1'b0;
  logic             memLocal;
  logic             memWrite;
  logic [3:0]       memType;
  logic [31:0]      memTarget;
  logic [OFS_W-1:0] memAddr;
  logic [31:0]      memWdata;
  logic [31:0]      memRdata = '0;
  logic             memAbort = 1'b0;
  logic             rspValid;
  logic [31:0]      rspRdata;
  logic             rspError;

  cfg_access_xlate #(.OFS_W(OFS_W)) i_cfg_access_xlate (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqBus(reqBus), .reqDev(reqDev), .reqFunc(reqFunc), .reqOffset(reqOffset),
    .reqWrite(reqWrite), .reqByteEn(reqByteEn), .reqWdata(reqWdata),
    .memValid(memValid), .memAck(memAck), .memLocal(memLocal), .memWrite(memWrite),
    .memType(memType), .memTarget(memTarget), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAbort(memAbort),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspError(rspError)
  );

  int testsRun = 0;
  int testsFailed = 0;

  // fabric model: key = {local, target[31:16], word address}
  logic [31:0] fabric [logic [28:0]];

  function automatic logic [28:0] keyOf(logic loc, logic [31:0] tgt, logic [OFS_W-1:0] adr);
    return {loc, (loc ? 16'h0 : tgt[31:16]), adr};
  endfunction

  function automatic logic [31:0] seedVal(logic [28:0] k);
    return ({3'b0, k} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] peek(logic [28:0] k);
    return fabric.exists(k) ? fabric[k] : seedVal(k);
  endfunction

  function automatic logic abortsAt(logic loc, logic [31:0] tgt);
    return !loc && (tgt[23:19] == 5'd7);
  endfunction

  function automatic logic [31:0] mergeBytes(logic [31:0] nw, logic [31:0] old, logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = be[i] ? nw[i*8 +: 8] : old[i*8 +: 8];
    return r;
  endfunction

  // expected access fields, set before each request
  logic             expLocal;
  logic [3:0]       expType;
  logic [31:0]      expTarget;
  logic [OFS_W-1:0] expAddr;
  logic             expPartial;
  int accCount, rdCount, wrCount, fieldErr, seqErr;
  int ackDelay = 0;

  // fabric responder
  always @(negedge clk) begin
    if (!rstN) begin
      memAck = 1'b0;
    end else if (memAck) begin
      memAck = 1'b0;
    end else if (memValid) begin
      if (ackDelay != 0) begin
        ackDelay--;
      end else begin
        logic [28:0] k;
        k = keyOf(memLocal, memTarget, memAddr);
        accCount++;
        if (memLocal !== expLocal || memType !== expType || memAddr !== expAddr ||
            (!expLocal && memTarget !== expTarget))
          fieldErr++;
        memAbort = abortsAt(memLocal, memTarget);
        if (memWrite) begin
          wrCount++;
          if (expPartial && rdCount == 0) seqErr++;
          if (!memAbort) fabric[k] = memWdata;
          memRdata = 32'hDEAD_BEEF;
        end else begin
          rdCount++;
          if (wrCount != 0) seqErr++;
          memRdata = memAbort ? 32'h1234_5678 : peek(k);
        end
        memAck = 1'b1;
        ackDelay = $urandom % 3;
      end
    end
  end

  task automatic check(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic doTxn(input logic [7:0] bus, input logic [4:0] dev, input logic [2:0] fn,
                       input logic [OFS_W-1:0] off, input logic wr, input logic [3:0] be,
                       input logic [31:0] wd);
    logic invalid, abrt;
    logic [28:0] k;
    logic [31:0] old, expRd, expNew;
    int waitCnt, readyErr;
    invalid    = (bus == 8'd0 && dev > 5'd1) || (bus == 8'd1 && dev > 5'd0);
    expLocal   = (bus == 8'd0);
    expType    = (bus < 8'd2) ? 4'h4 : 4'h5;
    expTarget  = {bus, dev, fn, 16'h0};
    expAddr    = {off[OFS_W-1:2], 2'b00};
    expPartial = wr && (be != 4'hF);
    k    = keyOf(expLocal, expTarget, expAddr);
    abrt = abortsAt(expLocal, expTarget);
    old  = peek(k);
    expRd  = abrt ? ONES : old;
    expNew = mergeBytes(wd, expRd, be);
    accCount = 0; rdCount = 0; wrCount = 0; fieldErr = 0; seqErr = 0; readyErr = 0;

    @(negedge clk);
    reqValid = 1'b1; reqBus = bus; reqDev = dev; reqFunc = fn; reqOffset = off;
    reqWrite = wr; reqByteEn = be; reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqWdata = $urandom;
    waitCnt = 0;
    while (!rspValid && waitCnt < 60) begin
      if (reqReady) readyErr++;
      @(negedge clk);
      waitCnt++;
    end
    check(rspValid, "R1 response pulse arrives", {31'b0, rspValid}, 32'h1);
    check(readyErr == 0 && !reqReady, "R1 reqReady low while busy", readyErr, 0);

    if (invalid) begin
      check(accCount == 0, wr ? "R4 no access on invalid write" : "R3 no access on invalid read", accCount, 0);
      if (wr) check(rspError == 1'b1, "R4 invalid write error (R2 filter)", {31'b0, rspError}, 32'h1);
      else begin
        check(rspRdata == ONES, "R3 invalid read all ones (R2 filter)", rspRdata, ONES);
        check(rspError == 1'b0, "R3 invalid read no error", {31'b0, rspError}, 32'h0);
      end
    end else begin
      check(fieldErr == 0, "R5 R6 R7 R8 access fields (R2 valid target)", fieldErr, 0);
      if (!wr) begin
        check(rdCount == 1 && wrCount == 0, "R9 single read access", accCount, 1);
        check(rspRdata == expRd, abrt ? "R9 aborted read all ones" : "R9 read data", rspRdata, expRd);
      end else if (!expPartial) begin
        check(rdCount == 0 && wrCount == 1, "R10 full write single access", {rdCount[15:0], wrCount[15:0]}, 32'h0000_0001);
        if (!abrt) check(peek(k) == wd, "R10 full write data", peek(k), wd);
        check(rspError == 1'b0, "R10 valid write no error", {31'b0, rspError}, 32'h0);
      end else begin
        check(rdCount == 1 && wrCount == 1 && seqErr == 0, "R11 read then write", {rdCount[15:0], wrCount[15:0]}, 32'h0001_0001);
        if (!abrt) check(peek(k) == expNew, "R11 byte merge", peek(k), expNew);
        check(rspError == 1'b0, "R11 valid write no error", {31'b0, rspError}, 32'h0);
      end
    end
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 reset idle ready", {31'b0, reqReady}, 32'h1);
    check(memValid == 1'b0 && rspValid == 1'b0, "R1 reset quiet", {30'b0, memValid, rspValid}, 32'h0);

    // directed boundary cases
    doTxn(8'd0, 5'd1, 3'd0, 12'h000, 1'b0, 4'h0, 32'h0);          // R2 bus0 dev1 valid
    doTxn(8'd0, 5'd2, 3'd0, 12'h010, 1'b0, 4'h0, 32'h0);          // R3 bus0 dev2 invalid read
    doTxn(8'd0, 5'd2, 3'd0, 12'h010, 1'b1, 4'hF, 32'hCAFE_0001);  // R4
    doTxn(8'd1, 5'd1, 3'd3, 12'h020, 1'b1, 4'h3, 32'hCAFE_0002);  // R4 bus1 dev1
    doTxn(8'd1, 5'd0, 3'd5, 12'h024, 1'b0, 4'h0, 32'h0);          // R6 bus1 type0 window
    doTxn(8'd2, 5'd0, 3'd0, 12'h028, 1'b0, 4'h0, 32'h0);          // R6 bus2 type1
    doTxn(8'hFF, 5'd31, 3'd7, 12'hFFF, 1'b0, 4'h0, 32'h0);        // R7 R8 extremes
    doTxn(8'h3C, 5'd9, 3'd2, 12'h103, 1'b1, 4'hF, 32'h0BAD_F00D); // R10
    doTxn(8'h3C, 5'd9, 3'd2, 12'h101, 1'b1, 4'h5, 32'h1122_3344); // R11 mixed lanes
    doTxn(8'h3C, 5'd9, 3'd2, 12'h100, 1'b0, 4'h0, 32'h0);         // R11 readback
    doTxn(8'd0, 5'd0, 3'd1, 12'h206, 1'b1, 4'h0, 32'hFFFF_0000);  // R11 empty enables
    doTxn(8'd4, 5'd7, 3'd0, 12'h040, 1'b0, 4'h0, 32'h0);          // R9 abort read
    doTxn(8'd4, 5'd7, 3'd0, 12'h040, 1'b1, 4'h2, 32'h0000_AB00);  // R11 abort in merge

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [7:0] b;
      logic [4:0] d;
      logic [3:0] e;
      int sel;
      sel = $urandom % 4;
      b = (sel == 3) ? 8'($urandom) : 8'(sel);
      d = ($urandom % 2 == 0) ? 5'($urandom % 3) : 5'($urandom);
      e = ($urandom % 3 == 0) ? 4'hF : 4'($urandom);
      doTxn(b, d, 3'($urandom), OFS_W'($urandom % 64), 1'($urandom), e, $urandom);
      repeat ($urandom % 3) @(negedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule